// File: doc/BRIEF.md
# Lowest-Priority Interrupt Router

This block takes the single request line of an interrupt controller and steers each request to exactly one of several processor cores. Every core writes the priority of the task it is running into a small per-core register in the block. When a request arrives, the block picks the core whose registered priority is the smallest. Larger values mean more important work and 0 means the core is in its idle loop, so the interrupt load lands on whichever core has the least important work at that moment. There is no fixed, broadcast or round-robin assignment.

The chosen core's interrupt line is held high until that core pulses its acknowledge. A request that arrives in the meantime is remembered, not lost. It is routed after the acknowledge, using the priorities held at that later time.

Top module: `irq_lowpri_router`

## Requirements
- R1: While reset is low, and after it is released, every `core_irq` bit is 0 and every core's priority register holds 0 (idle).
- R2: A rising edge of `ctl_req` seen at a clock edge while no request is outstanding sets exactly one `core_irq` bit after that same edge.
- R3: The target is the core whose priority register holds the smallest unsigned value. A core at 0 (idle) is chosen ahead of any core with a nonzero value.
- R4: When several cores share the smallest value, the core with the lowest index is chosen.
- R5: `prio_we[i]` loads slice i of `prio_wdata` (bits i*PRIO_W upward) at the clock edge. Selection at an edge uses the values held before that edge, so a write made in the same cycle as a request edge does not affect that request.
- R6: While a request is outstanding, its target does not change, even if priorities are rewritten.
- R7: The asserted line stays high until the target core's `core_ack` bit is high at a clock edge. Acknowledges from other cores, or acknowledges given while nothing is outstanding, have no effect.
- R8: At the edge where the target acknowledges, all `core_irq` bits go low. A request edge that arrived while the request was outstanding is delivered at the next edge, routed by the priorities current then.
- R9: Any number of request edges that arrive while one request is outstanding merge into a single pending delivery.
- R10: Requests are edge-triggered. Holding `ctl_req` high yields one delivery only.
- R11: At most one `core_irq` bit is high at any time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_req | input | 1 | Request from the interrupt controller; its rising edge is the event |
| prio_we | input | NUM_CORES | Per-core write enable for the priority registers |
| prio_wdata | input | NUM_CORES*PRIO_W | Priority values, core i in slice i |
| core_ack | input | NUM_CORES | Per-core acknowledge pulse |
| core_irq | output | NUM_CORES | Per-core interrupt line |

## Verification
A request edge sampled at clock edge k shows up on `core_irq` right after edge k, with no added latency. A priority write at edge k counts only for selections at edge k+1 or later. An acknowledge sampled at edge a clears the line after edge a, and a pending request reappears after edge a+1. The bench drives inputs just after a falling edge and reads the outputs at the next falling edge, so each result is compared in the half cycle after the edge that should produce it. The pending and edge-merge cases are checked across two cycles: the gap cycle and the redelivery cycle.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;

  // Dispatcher state: idle, or waiting for the chosen core to acknowledge.
  typedef enum logic [0:0] {
    RT_IDLE = 1'b0,
    RT_WAIT = 1'b1
  } route_state_e;

  // One-hot decode of a core index into a vector of the given width.
  function automatic logic [7:0] idx_to_onehot(input logic [2:0] idx);
    logic [7:0] v;
    v = '0;
    v[idx] = 1'b1;
    return v;
  endfunction

endpackage

// File: rtl/irq_prio_bank.sv
module irq_prio_bank #(
  parameter int NUM_CORES = 4,
  parameter int PRIO_W    = 4
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic [NUM_CORES-1:0]               wr_en,
  input  logic [NUM_CORES-1:0][PRIO_W-1:0]   wr_val,
  output logic [NUM_CORES-1:0][PRIO_W-1:0]   prio_q
);

  // One register per core, each with its own write enable.
  for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
    logic [PRIO_W-1:0] val_nxt;

    always_comb begin
      val_nxt = prio_q[c];
      if (wr_en[c]) val_nxt = wr_val[c];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prio_q[c] <= '0;
      else        prio_q[c] <= val_nxt;
    end
  end

endmodule

// File: rtl/irq_min_pick.sv
module irq_min_pick #(
  parameter int NUM_CORES = 4,
  parameter int PRIO_W    = 4,
  localparam int IDX_W    = $clog2(NUM_CORES)
) (
  input  logic [NUM_CORES-1:0][PRIO_W-1:0] prio,
  output logic [IDX_W-1:0]                 pick_idx
);

  // Linear scan with strict less-than: the first core holding the minimum wins.
  logic [PRIO_W-1:0] best_val;

  always_comb begin
    best_val = prio[0];
    pick_idx = '0;
    for (int c = 1; c < NUM_CORES; c++) begin
      if (prio[c] < best_val) begin
        best_val = prio[c];
        pick_idx = IDX_W'(c);
      end
    end
  end

endmodule

// File: rtl/irq_req_tracker.sv
module irq_req_tracker (
  input  logic clk,
  input  logic rst_n,
  input  logic ctl_req,
  input  logic take,      // dispatcher consumes the available request
  output logic avail      // a fresh edge or a held request is waiting
);

  logic req_d;
  logic pend_q, pend_nxt;
  logic req_edge;

  assign req_edge = ctl_req & ~req_d;
  assign avail    = pend_q | req_edge;

  always_comb begin
    pend_nxt = pend_q;
    if (take)          pend_nxt = 1'b0;
    else if (req_edge) pend_nxt = 1'b1;   // extra edges fold into one flag
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_d  <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      req_d  <= ctl_req;
      pend_q <= pend_nxt;
    end
  end

endmodule

// File: rtl/irq_dispatch_fsm.sv
module irq_dispatch_fsm
  import irq_route_pkg::*;
#(
  parameter int NUM_CORES = 4,
  localparam int IDX_W    = $clog2(NUM_CORES)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 avail,
  input  logic [IDX_W-1:0]     pick_idx,
  input  logic [NUM_CORES-1:0] core_ack,
  output logic                 take,
  output logic [NUM_CORES-1:0] core_irq
);

  route_state_e         st_q, st_nxt;
  logic [IDX_W-1:0]     tgt_q;
  logic                 tgt_en;
  logic [NUM_CORES-1:0] irq_nxt;
  logic [7:0]           pick_oh;

  assign pick_oh = idx_to_onehot(3'(pick_idx));

  always_comb begin
    st_nxt  = st_q;
    take    = 1'b0;
    tgt_en  = 1'b0;
    irq_nxt = core_irq;
    unique case (st_q)
      RT_IDLE: begin
        if (avail) begin
          take    = 1'b1;
          tgt_en  = 1'b1;
          st_nxt  = RT_WAIT;
          irq_nxt = pick_oh[NUM_CORES-1:0];
        end
      end
      RT_WAIT: begin
        if (core_ack[tgt_q]) begin
          st_nxt  = RT_IDLE;
          irq_nxt = '0;
        end
      end
      default: st_nxt = RT_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= RT_IDLE;
      core_irq <= '0;
    end else begin
      st_q     <= st_nxt;
      core_irq <= irq_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      tgt_q <= '0;
    else if (tgt_en) tgt_q <= pick_idx;
  end

endmodule

// File: rtl/irq_lowpri_router.sv
module irq_lowpri_router #(
  parameter int NUM_CORES = 4,
  parameter int PRIO_W    = 4,
  localparam int IDX_W    = $clog2(NUM_CORES)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        ctl_req,
  input  logic [NUM_CORES-1:0]        prio_we,
  input  logic [NUM_CORES*PRIO_W-1:0] prio_wdata,
  input  logic [NUM_CORES-1:0]        core_ack,
  output logic [NUM_CORES-1:0]        core_irq
);

  logic [NUM_CORES-1:0][PRIO_W-1:0] wr_val;
  logic [NUM_CORES-1:0][PRIO_W-1:0] prio_q;
  logic [IDX_W-1:0]                 pick_idx;
  logic                             avail;
  logic                             take;

  assign wr_val = prio_wdata;

  irq_prio_bank #(.NUM_CORES(NUM_CORES), .PRIO_W(PRIO_W)) u_bank (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (prio_we),
    .wr_val (wr_val),
    .prio_q (prio_q)
  );

  irq_min_pick #(.NUM_CORES(NUM_CORES), .PRIO_W(PRIO_W)) u_pick (
    .prio     (prio_q),
    .pick_idx (pick_idx)
  );

  irq_req_tracker u_trk (
    .clk     (clk),
    .rst_n   (rst_n),
    .ctl_req (ctl_req),
    .take    (take),
    .avail   (avail)
  );

  irq_dispatch_fsm #(.NUM_CORES(NUM_CORES)) u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .avail    (avail),
    .pick_idx (pick_idx),
    .core_ack (core_ack),
    .take     (take),
    .core_irq (core_irq)
  );

endmodule

// File: rtl/irq_route_chk.sv
module irq_route_chk #(
  parameter int NUM_CORES = 4
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [NUM_CORES-1:0] core_ack,
  input logic [NUM_CORES-1:0] core_irq
);

  AST_RESET_QUIET: assert property (@(posedge clk) !rst_n |-> core_irq == '0);  // R1

  AST_SINGLE_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(core_irq));  // R11

  AST_HOLD_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    (core_irq != '0 && (core_irq & core_ack) == '0) |=> core_irq == $past(core_irq));  // R6

  AST_FOREIGN_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    (core_irq != '0 && (core_ack & ~core_irq) != '0 && (core_ack & core_irq) == '0)
      |=> core_irq == $past(core_irq));  // R7

  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    ((core_irq & core_ack) != '0) |=> core_irq == '0);  // R8

endmodule

bind irq_lowpri_router irq_route_chk #(.NUM_CORES(NUM_CORES)) u_route_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .core_ack (core_ack),
  .core_irq (core_irq)
);

// File: tb/irq_lowpri_router_bench.sv
module irq_lowpri_router_bench;

  localparam int N = 4;
  localparam int W = 4;
  localparam int NV = 7;

  logic           clk;
  logic           rst_n;
  logic           ctl_req;
  logic [N-1:0]   prio_we;
  logic [N*W-1:0] prio_wdata;
  logic [N-1:0]   core_ack;
  logic [N-1:0]   core_irq;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  // {priorities core3..core0, expected one-hot target}
  localparam logic [19:0] VEC [NV] = '{
    {16'h0000, 4'b0001},   // all idle: lowest index
    {16'h0321, 4'b1000},   // only core3 idle
    {16'h5074, 4'b0100},   // core2 idle
    {16'h9A2B, 4'b0010},   // all busy, core1 smallest
    {16'h3131, 4'b0001},   // tie core0/core2
    {16'h22F5, 4'b0100},   // tie core2/core3
    {16'hEFFF, 4'b1000}    // smallest at top index
  };

  irq_lowpri_router #(.NUM_CORES(N), .PRIO_W(W)) u_irq_lowpri_router (
    .clk(clk), .rst_n(rst_n), .ctl_req(ctl_req), .prio_we(prio_we),
    .prio_wdata(prio_wdata), .core_ack(core_ack), .core_irq(core_irq)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;   // 50 MHz

  task automatic step();
    @(negedge clk);
  endtask

  task automatic check(input string req, input logic [N-1:0] got, input logic [N-1:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: core_irq=%b expected=%b", req, got, exp);
    end
  endtask

  task automatic write_all(input logic [N*W-1:0] v);
    prio_we = '1; prio_wdata = v;
    step();
    prio_we = '0;
  endtask

  task automatic pulse_req();
    ctl_req = 1'b1;
    step();
    ctl_req = 1'b0;
  endtask

  task automatic ack_core(input int c);
    core_ack = N'(1) << c;
    step();
    core_ack = '0;
  endtask

  initial begin
    rst_n = 1'b0; ctl_req = 1'b0; prio_we = '0; prio_wdata = '0; core_ack = '0;
    step(); step();
    check("R1 during reset", core_irq, '0);
    rst_n = 1'b1;
    step();
    check("R1 after reset", core_irq, '0);
    pulse_req();
    check("R1 reset priorities idle -> core0", core_irq, 4'b0001);
    ack_core(0);
    check("R8 ack clears", core_irq, '0);

    // Table: R2 delivery, R3 lowest priority, R4 ties
    for (int i = 0; i < NV; i++) begin
      write_all(VEC[i][19:4]);
      pulse_req();
      check("R2 R3 R4 table target", core_irq, VEC[i][3:0]);
      for (int c = 0; c < N; c++) if (VEC[i][c]) ack_core(c);
      check("R8 table ack clears", core_irq, '0);
    end

    // R5: write in same cycle as request edge is not used
    write_all(16'h1230);
    prio_we = 4'b0001; prio_wdata = 16'h0009; ctl_req = 1'b1;
    step();
    prio_we = '0; ctl_req = 1'b0;
    check("R5 same-cycle write ignored", core_irq, 4'b0001);
    ack_core(0);
    pulse_req();
    check("R5 written value used later", core_irq, 4'b1000);

    // R6: rewrite target's priority while outstanding
    prio_we = 4'b1000; prio_wdata = 16'hF000;
    step();
    prio_we = '0;
    step();
    check("R6 target held", core_irq, 4'b1000);
    // R7: foreign acknowledge ignored
    ack_core(0);
    check("R7 foreign ack ignored", core_irq, 4'b1000);
    ack_core(3);
    check("R8 ack clears", core_irq, '0);
    ack_core(1);
    check("R7 ack while idle ignored", core_irq, '0);

    // R8/R9: pending requests while outstanding
    write_all(16'h0000);
    pulse_req();
    check("R2 deliver core0", core_irq, 4'b0001);
    pulse_req();
    step();
    pulse_req();
    prio_we = 4'b0001; prio_wdata = 16'h0005;
    step();
    prio_we = '0;
    check("R9 still held before ack", core_irq, 4'b0001);
    ack_core(0);
    check("R8 gap after ack", core_irq, '0);
    step();
    check("R8 pending redelivered with new priorities", core_irq, 4'b0010);
    ack_core(1);
    check("R8 ack clears", core_irq, '0);
    step();
    check("R9 merged edges give one delivery", core_irq, '0);

    // R10: level held high yields one delivery
    ctl_req = 1'b1;
    step();
    check("R10 first delivery", core_irq, 4'b0010);
    ack_core(1);
    step(); step();
    check("R10 no redelivery on held level", core_irq, '0);
    ctl_req = 1'b0;
    step();

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: run hung");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule